// File: doc/BRIEF.md
# Three-Multiplier Dual-Width Complex Multiplier

This block forms the product of a complex data sample and a complex twiddle factor, as needed in an FFT butterfly. It uses three real multipliers rather than four. The data parts are `ar` and `ai`, and the twiddle parts are `br` and `bi`. A pre-subtracted term, `ai·(br−bi)`, is shared between the two outputs:

- real = `br·(ar−ai) + ai·(br−bi)`
- imaginary = `bi·(ar+ai) + ai·(br−bi)`

Each real multiplier is a twin-precision signed array. It either multiplies two full-width operands, or it multiplies two independent half-width pairs in its low and high lanes.

In full mode the operands are `W` bits wide and every multiplier computes one wide product. In half mode only the low `W/2` bits of each operand are used. Two of the three narrow products share the lanes of the first multiplier. The third product sits in the low lane of the second multiplier. The last multiplier receives all-zero operands, so it stays idle.

Results keep full precision and pass through one register stage. A valid strobe travels with them. FFT sequencing, twiddle storage and output rounding belong to the surrounding design.

Top module: `cplx_mul3_twin`

## Requirements
- R1: With `half_mode`=0, the registered `re_out` equals ar·br − ai·bi exactly. All operands are signed two's-complement `W`-bit values, and the result is `2W+1` bits.
- R2: With `half_mode`=0, the registered `im_out` equals ar·bi + ai·br exactly, in `2W+1` bits.
- R3: With `half_mode`=1, the operands are bits `[W/2-1:0]` of each input, read as signed. `re_out` and `im_out` carry the same two formulas computed on these narrow operands, sign-extended to `2W+1` bits.
- R4: With `half_mode`=1, bits `[W-1:W/2]` of `ar`, `ai`, `br` and `bi` have no effect on the outputs.
- R5: `out_valid` equals the value of `in_valid` at the preceding rising clock edge. The result of a sample accepted at edge k appears after edge k.
- R6: When `in_valid` is 0 at an edge, `re_out` and `im_out` keep their previous values.
- R7: Corner operands give exact results in both modes. These include the most negative value in every position, the most positive value, and zero.
- R8: While `rst_n` is 0 at a rising edge, `out_valid`, `re_out` and `im_out` are cleared to 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| half_mode | input | 1 | 0 = full width, 1 = half width on the low bits |
| in_valid | input | 1 | Input sample strobe |
| ar | input | W | Data real part |
| ai | input | W | Data imaginary part |
| br | input | W | Twiddle real part |
| bi | input | W | Twiddle imaginary part |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| re_out | output | 2W+1 | Real result, signed |
| im_out | output | 2W+1 | Imaginary result, signed |

## Verification
The assertions take for granted that `half_mode` is steady while `in_valid` is high. They also take for granted that `W` is even, so that both twin lanes have the same width. The bench changes the mode only together with a new sample. It drives every input half a period away from the capturing edge.

Because the overflow checks rely on the arithmetic being exact, the stimulus includes the most negative operand in every position. The stimulus also places random upper-half bits in half mode, to show that they are ignored.

// File: rtl/cm3_pkg.sv
// Shared definitions for the three-multiplier complex product.
// Assumes: nothing beyond IEEE 1800-2017.
package cm3_pkg;
    // Operating width selector; the value carried on the half_mode pin.
    typedef enum logic {
        CM3_FULL = 1'b0,
        CM3_HALF = 1'b1
    } cm3_mode_e;

    // Number of real multipliers in the datapath.
    localparam int CM3_NMUL = 3;
endpackage

// File: rtl/cm3_operand_pack.sv
// Forms the pre-added and pre-subtracted terms and routes the operands to the
// three twin multipliers.
// Full mode:  mult0 = br*(ar-ai), mult1 = ai*(br-bi), mult2 = bi*(ar+ai).
// Half mode:  mult0 low lane = br*(ar-ai), mult0 high lane = ai*(br-bi),
//             mult1 low lane = bi*(ar+ai), mult2 gets zeros (idle).
// Assumes: W is even; lanes are W/2+1 bits wide, so 2 lanes = W+2 bits.
module cm3_operand_pack
    import cm3_pkg::*;
#(
    parameter int W = 32
) (
    input  cm3_mode_e                     mode,
    input  logic [W-1:0]                  ar,
    input  logic [W-1:0]                  ai,
    input  logic [W-1:0]                  br,
    input  logic [W-1:0]                  bi,
    output logic [CM3_NMUL-1:0][W+1:0]    op_x,
    output logic [CM3_NMUL-1:0][W+1:0]    op_y
);
    localparam int M = W + 2;
    localparam int H = W / 2;
    localparam int L = H + 1;

    logic [W:0]   f_dsub, f_dadd, f_tsub;
    logic [L-1:0] n_dsub, n_dadd, n_tsub;

    // Pre-adder and pre-subtractors, one bit wider than their inputs.
    always_comb begin
        f_dsub = {ar[W-1], ar} - {ai[W-1], ai};
        f_dadd = {ar[W-1], ar} + {ai[W-1], ai};
        f_tsub = {br[W-1], br} - {bi[W-1], bi};
        n_dsub = {ar[H-1], ar[H-1:0]} - {ai[H-1], ai[H-1:0]};
        n_dadd = {ar[H-1], ar[H-1:0]} + {ai[H-1], ai[H-1:0]};
        n_tsub = {br[H-1], br[H-1:0]} - {bi[H-1], bi[H-1:0]};
    end

    // Operand routing per mode; the idle multiplier sees zeros in half mode.
    always_comb begin
        if (mode == CM3_HALF) begin
            op_x[0] = {ai[H-1], ai[H-1:0], br[H-1], br[H-1:0]};
            op_y[0] = {n_tsub, n_dsub};
            op_x[1] = {{L{1'b0}}, bi[H-1], bi[H-1:0]};
            op_y[1] = {{L{1'b0}}, n_dadd};
            op_x[2] = '0;
            op_y[2] = '0;
        end else begin
            op_x[0] = {{(M-W){br[W-1]}}, br};
            op_y[0] = {f_dsub[W], f_dsub};
            op_x[1] = {{(M-W){ai[W-1]}}, ai};
            op_y[1] = {f_tsub[W], f_tsub};
            op_x[2] = {{(M-W){bi[W-1]}}, bi};
            op_y[2] = {f_dadd[W], f_dadd};
        end
    end
endmodule

// File: rtl/cm3_twin_mult.sv
// Twin-precision signed multiplier built from one AND array of partial
// products. Full mode: M x M signed product. Twin mode: the cross-lane partial
// products are dropped and each lane is an independent (M/2)x(M/2) signed
// product, low lane in p[M-1:0] and high lane in p[2M-1:M].
// Assumes: M is even. Sign handling is weighting each partial-product bit
// negative when exactly one of its indices is a sign position.
module cm3_twin_mult #(
    parameter int M = 34
) (
    input  logic           twin,
    input  logic [M-1:0]   a,
    input  logic [M-1:0]   b,
    output logic [2*M-1:0] p
);
    localparam int L = M / 2;

    logic [2*M-1:0] full_acc, f_term;
    logic [M-1:0]   lo_acc, hi_acc, l_term;
    logic           pp;

    // Accumulate the shared partial-product array into full and lane sums.
    always_comb begin
        full_acc = '0;
        lo_acc   = '0;
        hi_acc   = '0;
        f_term   = '0;
        l_term   = '0;
        pp       = 1'b0;
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
                pp          = a[i] & b[j];
                f_term      = '0;
                f_term[i+j] = pp;
                if ((i == M-1) != (j == M-1)) full_acc = full_acc - f_term;
                else                          full_acc = full_acc + f_term;
                l_term = '0;
                if (i < L && j < L) begin
                    l_term[i+j] = pp;
                    if ((i == L-1) != (j == L-1)) lo_acc = lo_acc - l_term;
                    else                          lo_acc = lo_acc + l_term;
                end else if (i >= L && j >= L) begin
                    l_term[i+j-2*L] = pp;
                    if ((i == M-1) != (j == M-1)) hi_acc = hi_acc - l_term;
                    else                          hi_acc = hi_acc + l_term;
                end
            end
        end
        p = twin ? {hi_acc, lo_acc} : full_acc;
    end
endmodule

// File: rtl/cplx_mul3_twin.sv
// Complex multiplier using three twin-precision real multipliers and one
// output register stage. Full mode computes W-bit operands. Half mode computes
// the low W/2 bits, with one multiplier idle.
// Assumes: W even and >= 4; half_mode steady while in_valid is high.
module cplx_mul3_twin
    import cm3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_mode,
    input  logic            in_valid,
    input  logic [W-1:0]    ar,
    input  logic [W-1:0]    ai,
    input  logic [W-1:0]    br,
    input  logic [W-1:0]    bi,
    output logic            out_valid,
    output logic [2*W:0]    re_out,
    output logic [2*W:0]    im_out
);
    localparam int M  = W + 2;
    localparam int OW = 2 * W + 1;

    cm3_mode_e                     mode;
    logic [CM3_NMUL-1:0][M-1:0]    op_x, op_y;
    logic [CM3_NMUL-1:0][2*M-1:0]  prod;
    logic [2*M-1:0]                re_wide, im_wide;
    logic [M-1:0]                  re_nar, im_nar;
    logic [OW-1:0]                 re_sel, im_sel;

    assign mode = cm3_mode_e'(half_mode);

    cm3_operand_pack #(.W(W)) u_pack (
        .mode (mode),
        .ar   (ar),
        .ai   (ai),
        .br   (br),
        .bi   (bi),
        .op_x (op_x),
        .op_y (op_y)
    );

    for (genvar g = 0; g < CM3_NMUL; g++) begin : g_mul
        cm3_twin_mult #(.M(M)) u_mul (
            .twin (mode == CM3_HALF),
            .a    (op_x[g]),
            .b    (op_y[g]),
            .p    (prod[g])
        );
    end

    // Post-adders: combine the shared term with each output's own product.
    always_comb begin
        re_wide = prod[0] + prod[1];
        im_wide = prod[2] + prod[1];
        re_nar  = prod[0][M-1:0] + prod[0][2*M-1:M];
        im_nar  = prod[1][M-1:0] + prod[0][2*M-1:M];
        if (mode == CM3_HALF) begin
            re_sel = {{(OW-M){re_nar[M-1]}}, re_nar};
            im_sel = {{(OW-M){im_nar[M-1]}}, im_nar};
        end else begin
            re_sel = re_wide[OW-1:0];
            im_sel = im_wide[OW-1:0];
        end
    end

    // Output register stage; data captured only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            re_out    <= '0;
            im_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                re_out <= re_sel;
                im_out <= im_sel;
            end
        end
    end

    // Strobe follows the input one cycle later.
    assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Results hold between valid samples.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(re_out) && $stable(im_out)));

    // The wide sums never need more than 2W+1 bits.
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == CM3_FULL) |->
        (re_wide[2*M-1:OW-1] == '0 || re_wide[2*M-1:OW-1] == '1));
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == CM3_FULL) |->
        (im_wide[2*M-1:OW-1] == '0 || im_wide[2*M-1:OW-1] == '1));

    // Half mode: the third multiplier stays at zero.
    assert_idle_mult_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM3_HALF) |-> (prod[2] == '0));

    // Half-mode results fit W+1 bits once registered.
    assert_half_extend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == CM3_HALF) |=>
        ((re_out[OW-1:W] == '0 || re_out[OW-1:W] == '1) &&
         (im_out[OW-1:W] == '0 || im_out[OW-1:W] == '1)));
endmodule

// File: tb/cplx_mul3_twin_tb_top.sv
module cplx_mul3_twin_tb_top;
    localparam int W  = 8;
    localparam int H  = W / 2;
    localparam int OW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          half_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  ar = '0, ai = '0, br = '0, bi = '0;
    logic          out_valid;
    logic [OW-1:0] re_out, im_out;

    int checks = 0;
    int fails  = 0;

    // Expected state of the outputs after the next edge.
    bit    exp_v = 1'b0;
    int    exp_re = 0, exp_im = 0;
    string tag_re = "R8", tag_im = "R8";

    always #5 clk = ~clk;

    cplx_mul3_twin #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .in_valid(in_valid),
        .ar(ar), .ai(ai), .br(br), .bi(bi),
        .out_valid(out_valid), .re_out(re_out), .im_out(im_out)
    );

    function automatic int sx(input logic [W-1:0] x, input int n);
        int v;
        v = int'(x) & ((1 << n) - 1);
        if (v >= (1 << (n - 1))) v = v - (1 << n);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        int ar_i, ai_i;
        ar_i = int'($signed(re_out));
        ai_i = int'($signed(im_out));
        chk(out_valid == exp_v, "R5", int'(out_valid), int'(exp_v));
        chk(ar_i == exp_re, tag_re, ar_i, exp_re);
        chk(ai_i == exp_im, tag_im, ai_i, exp_im);
    endtask

    // One cycle: check the previous cycle's result, then drive a new sample.
    task automatic step(input bit v, input bit hm, input logic [W-1:0] a_r,
                        input logic [W-1:0] a_i, input logic [W-1:0] b_r,
                        input logic [W-1:0] b_i, input string t_re, input string t_im);
        int n, xr, xi, yr, yi;
        @(negedge clk);
        compare();
        in_valid  = v;
        half_mode = hm;
        ar = a_r; ai = a_i; br = b_r; bi = b_i;
        if (rst_n) begin
            exp_v = v;
            if (v) begin
                n  = hm ? H : W;
                xr = sx(a_r, n); xi = sx(a_i, n);
                yr = sx(b_r, n); yi = sx(b_i, n);
                exp_re = xr * yr - xi * yi;
                exp_im = xr * yi + xi * yr;
                tag_re = t_re;
                tag_im = t_im;
            end else begin
                tag_re = "R6";
                tag_im = "R6";
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: valid samples during reset leave outputs cleared.
        step(1, 0, 8'h7f, 8'h80, 8'h80, 8'h7f, "R8", "R8");
        step(1, 1, 8'h55, 8'h33, 8'h21, 8'h9c, "R8", "R8");
        step(1, 0, 8'h12, 8'h34, 8'h56, 8'h78, "R8", "R8");
        rst_n    = 1'b1;
        in_valid = 1'b0;
        step(0, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R8", "R8");

        // R1 R2: full-mode directed patterns.
        step(1, 0, 8'd3,  8'd5,  8'd7,  8'd11,  "R1", "R2");
        step(1, 0, 8'hfd, 8'd9,  8'd4,  8'hf0,  "R1", "R2");
        step(1, 0, 8'd1,  8'd0,  8'd0,  8'd1,   "R1", "R2");
        // R7: full-mode corners.
        step(1, 0, 8'h80, 8'h80, 8'h80, 8'h80, "R7", "R7");
        step(1, 0, 8'h80, 8'h7f, 8'h7f, 8'h80, "R7", "R7");
        step(1, 0, 8'h7f, 8'h7f, 8'h7f, 8'h7f, "R7", "R7");
        step(1, 0, 8'h80, 8'h00, 8'h80, 8'h00, "R7", "R7");
        step(1, 0, 8'h00, 8'h80, 8'h7f, 8'h80, "R7", "R7");
        // R6: hold across idle cycles.
        step(0, 0, 8'h11, 8'h22, 8'h33, 8'h44, "R6", "R6");
        step(0, 1, 8'hff, 8'hff, 8'hff, 8'hff, "R6", "R6");
        // R3: half mode directed and corners.
        step(1, 1, 8'h03, 8'h05, 8'h02, 8'h07, "R3", "R3");
        step(1, 1, 8'h08, 8'h08, 8'h08, 8'h08, "R7", "R7");
        step(1, 1, 8'h08, 8'h07, 8'h07, 8'h08, "R7", "R7");
        step(1, 1, 8'h07, 8'h07, 8'h07, 8'h07, "R7", "R7");
        // R4: same low bits, different upper bits, same results.
        step(1, 1, 8'h0c, 8'h03, 8'h09, 8'h05, "R4", "R4");
        step(1, 1, 8'hfc, 8'ha3, 8'h59, 8'h75, "R4", "R4");
        step(1, 1, 8'h7c, 8'h83, 8'he9, 8'h35, "R4", "R4");
        // Mode alternation back to back.
        step(1, 0, 8'h9a, 8'h44, 8'hc3, 8'h1e, "R1", "R2");
        step(1, 1, 8'h9a, 8'h44, 8'hc3, 8'h1e, "R3", "R3");
        step(1, 0, 8'h80, 8'h80, 8'h7f, 8'h7f, "R7", "R7");
        // Random stimulus in both modes with sparse idle cycles.
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] r0, r1, r2, r3;
            bit vv, hh;
            r0 = W'($urandom); r1 = W'($urandom);
            r2 = W'($urandom); r3 = W'($urandom);
            vv = ($urandom % 5) != 0;
            hh = $urandom % 2;
            if (hh) step(vv, hh, r0, r1, r2, r3, "R4", "R3");
            else    step(vv, hh, r0, r1, r2, r3, "R1", "R2");
        end
        step(0, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R6", "R6");
        step(0, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R6", "R6");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule